// File: doc/BRIEF.md
# SDRAM Refresh Burst and Power-Down Controller

This block decides when an SDRAM interface sends auto-refresh commands and when it lowers the clock enable to save power. A 16-bit refresh timer counts up toward a programmable threshold. When the timer reaches it, the block sends a burst of four or eight auto-refresh strobes, with a programmable number of idle cycles between them, instead of a single refresh. This keeps refresh overhead grouped and leaves longer stretches free for data traffic.

When power saving is enabled and the interface is idle, the controller drops CKE on its own. An access request or a due refresh first raises CKE and waits a fixed recovery time. Only then is a grant or a refresh strobe issued. A refresh that is due always beats a new access. The access grant is held back until the burst has finished. Data transfer and address mapping are handled elsewhere.

Top module: `sdram_refresh_pd_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, CKE is 1, the refresh strobe is 0 and the grant is 0.
- R2: The timer starts at 0 out of reset and counts one per cycle. In the cycle in which it equals `ref_thresh` and the interface is idle, a burst starts. The first strobe follows 2 cycles after that equality, so after reset it appears at cycle T+2. The timer restarts from 0 on the edge that starts the burst, so the next burst's first strobe comes at cycle 2T+3.
- R3: With `burst8` = 0 a burst holds exactly 4 strobes. With `burst8` = 1 it holds exactly 8.
- R4: Within a burst, consecutive strobes have `gap_cyc` idle cycles between them. A gap value of 0 acts as 1.
- R5: An access request that meets a refresh that has come due is not granted during the burst. The grant appears 2 cycles after the last strobe of the burst.
- R6: A due refresh does not start while `xact_active` is 1. It starts on the first edge at which `xact_active` is 0.
- R7: With `pd_en` = 1, CKE drops on the edge that finds the controller idle with `xact_active`, `acc_req` and the grant all low. CKE stays high while `xact_active` is 1.
- R8: An access request sampled on edge A while CKE is low raises CKE on edge A. The grant then appears on edge A+3. No grant or refresh is issued in the two cycles after CKE rises.
- R9: With `pd_en` = 0, CKE is 1 in every cycle.
- R10: The grant is a one-cycle pulse for each accepted request.
- R11: A refresh that comes due in power-down wakes the device first. The burst starts on the wake edge plus 3. After the burst the device returns to power-down. Every refresh strobe occurs while CKE is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_en | input | 1 | Enables automatic power-down between accesses |
| burst8 | input | 1 | 0: four strobes per burst, 1: eight strobes per burst |
| gap_cyc | input | 4 | Idle cycles between strobes in a burst (0 acts as 1) |
| ref_thresh | input | 16 | Timer value at which a burst comes due |
| xact_active | input | 1 | A transfer is in progress on the interface |
| acc_req | input | 1 | Access request, held until granted |
| cke | output | 1 | Clock enable to the memory |
| ref_cmd | output | 1 | One-cycle auto-refresh strobe |
| acc_grant | output | 1 | One-cycle access grant |

## Verification
Each output has a fixed delay in edges from the stimulus that causes it. The first strobe comes two edges after the timer equals the threshold. Later strobes follow every gap+1 edges. A grant comes three edges after a request wakes the device, and two edges after the last strobe of a burst that held it back. CKE changes on the very edge that samples its cause. The bench counts edges from the release of reset. For every cycle it builds the expected value of each output from these delays and compares it half a cycle after the edge, so it catches a result that is early, late or missing. A table of burst configurations checks every strobe position, including the restart of the timer. Directed runs cover the wake sequence, the priority of refresh over access, and the refresh path from power-down.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PD   = 2'd1,
    ST_WAKE = 2'd2,
    ST_REF  = 2'd3
  } pwr_state_t;

  localparam int SHORT_BURST = 4;
  localparam int LONG_BURST  = 8;
  localparam int WAKE_CYC    = 2;
endpackage

// File: rtl/srp_ref_timer.sv
module srp_ref_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [TW-1:0] thresh,
  output logic          due
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt < thresh) cnt <= cnt + 1'b1;
  end

  assign due = (cnt >= thresh);

  // R2
  timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (due && !clr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/srp_ref_burst.sv
module srp_ref_burst #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          burst8,
  input  logic [GW-1:0] gap,
  output logic          ref_cmd,
  output logic          busy
);
  import srp_pkg::*;
  localparam int LW = $clog2(LONG_BURST + 1);

  logic [LW-1:0] left;
  logic [GW-1:0] wait_q;
  logic [GW-1:0] gap_eff;

  assign gap_eff = (gap == '0) ? GW'(1) : gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      left    <= '0;
      wait_q  <= '0;
      ref_cmd <= 1'b0;
    end else begin
      ref_cmd <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          left   <= burst8 ? LW'(LONG_BURST) : LW'(SHORT_BURST);
          wait_q <= '0;
        end
      end else if (wait_q == '0) begin
        ref_cmd <= 1'b1;
        left    <= left - 1'b1;
        wait_q  <= gap_eff;
        if (left == LW'(1)) busy <= 1'b0;
      end else begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |=> !ref_cmd);
  // R3
  burst_left_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (left != '0 && left <= LW'(LONG_BURST)));
endmodule

// File: rtl/srp_pwr_fsm.sv
module srp_pwr_fsm (
  input  logic clk,
  input  logic rst,
  input  logic pd_en,
  input  logic xact_active,
  input  logic acc_req,
  input  logic ref_due,
  input  logic burst_busy,
  output logic start_ref,
  output logic cke,
  output logic acc_grant
);
  import srp_pkg::*;
  localparam int WCW = $clog2(WAKE_CYC + 1);

  pwr_state_t     st;
  logic [WCW-1:0] wcnt;

  assign start_ref = (st == ST_IDLE) && ref_due && !xact_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cke       <= 1'b1;
      acc_grant <= 1'b0;
      wcnt      <= '0;
    end else begin
      acc_grant <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_ref) begin
            st <= ST_REF;
          end else if (acc_req && !acc_grant && !ref_due) begin
            acc_grant <= 1'b1;
          end else if (pd_en && !xact_active && !acc_req && !acc_grant) begin
            st  <= ST_PD;
            cke <= 1'b0;
          end
        end
        ST_PD: begin
          if (ref_due || acc_req || !pd_en) begin
            st   <= ST_WAKE;
            cke  <= 1'b1;
            wcnt <= '0;
          end
        end
        ST_WAKE: begin
          if (wcnt == WCW'(WAKE_CYC - 1)) st <= ST_IDLE;
          else                            wcnt <= wcnt + 1'b1;
        end
        ST_REF: begin
          if (!burst_busy) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  grant_cke_chk: assert property (@(posedge clk) disable iff (rst)
    acc_grant |-> cke);
  // R8
  wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |=> (!acc_grant && !start_ref));
  // R9
  pd_off_cke_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pd_en) |-> cke);
  // R10
  grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    acc_grant |=> !acc_grant);
  // R5
  grant_vs_ref_chk: assert property (@(posedge clk) disable iff (rst)
    acc_grant |-> !burst_busy);
endmodule

// File: rtl/sdram_refresh_pd_ctrl.sv
module sdram_refresh_pd_ctrl #(
  parameter int TW = 16,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pd_en,
  input  logic          burst8,
  input  logic [GW-1:0] gap_cyc,
  input  logic [TW-1:0] ref_thresh,
  input  logic          xact_active,
  input  logic          acc_req,
  output logic          cke,
  output logic          ref_cmd,
  output logic          acc_grant
);
  logic due;
  logic start_ref;
  logic busy;

  srp_ref_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .clr(start_ref), .thresh(ref_thresh), .due(due)
  );

  srp_ref_burst #(.GW(GW)) u_burst (
    .clk(clk), .rst(rst), .start(start_ref), .burst8(burst8), .gap(gap_cyc),
    .ref_cmd(ref_cmd), .busy(busy)
  );

  srp_pwr_fsm u_fsm (
    .clk(clk), .rst(rst), .pd_en(pd_en), .xact_active(xact_active),
    .acc_req(acc_req), .ref_due(due), .burst_busy(busy),
    .start_ref(start_ref), .cke(cke), .acc_grant(acc_grant)
  );

  // R11
  ref_cke_chk: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> cke);
endmodule

// File: tb/test_sdram_refresh_pd_ctrl.sv
module test_sdram_refresh_pd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pd_en = 1'b0;
  logic        burst8 = 1'b0;
  logic [3:0]  gap_cyc = 4'd1;
  logic [15:0] ref_thresh = 16'd1000;
  logic        xact_active = 1'b0;
  logic        acc_req = 1'b0;
  logic        cke, ref_cmd, acc_grant;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_refresh_pd_ctrl i_sdram_refresh_pd_ctrl (
    .clk(clk), .rst(rst), .pd_en(pd_en), .burst8(burst8), .gap_cyc(gap_cyc),
    .ref_thresh(ref_thresh), .xact_active(xact_active), .acc_req(acc_req),
    .cke(cke), .ref_cmd(ref_cmd), .acc_grant(acc_grant)
  );

  // vector fields: [20] burst8, [19:16] gap, [15:0] threshold
  localparam logic [20:0] VEC [5] = '{
    {1'b0, 4'd1, 16'd30},
    {1'b1, 4'd1, 16'd50},
    {1'b0, 4'd3, 16'd40},
    {1'b1, 4'd2, 16'd100},
    {1'b0, 4'd0, 16'd25}
  };

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs in reset
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 cke", cke == 1'b1, cke, 1);
    chk("R1 ref_cmd", ref_cmd == 1'b0, ref_cmd, 0);
    chk("R1 grant", acc_grant == 1'b0, acc_grant, 0);

    // Table: burst positions, length, gap and timer restart (R2 R3 R4)
    for (int v = 0; v < 5; v++) begin
      int t, g, n, k;
      burst8 = VEC[v][20];
      gap_cyc = VEC[v][19:16];
      ref_thresh = VEC[v][15:0];
      pd_en = 1'b0;
      xact_active = 1'b0;
      acc_req = 1'b0;
      t = int'(VEC[v][15:0]);
      g = (VEC[v][19:16] == 4'd0) ? 1 : int'(VEC[v][19:16]);
      n = VEC[v][20] ? 8 : 4;
      k = 0;
      do_reset();
      for (int c = 1; c <= 2 * t + 4; c++) begin
        int exp_t;
        step();
        if (ref_cmd) begin
          exp_t = (k < n) ? (t + 2 + k * (g + 1)) : (2 * t + 3);
          if (k == 0 || k == n) chk("R2 strobe time", cyc == exp_t, cyc, exp_t);
          else                  chk("R4 strobe spacing", cyc == exp_t, cyc, exp_t);
          k++;
        end
      end
      chk("R3 strobe count", k == n + 1, k, n + 1);
    end

    // R9: power-down disabled keeps CKE high
    begin
      int low;
      pd_en = 1'b0; ref_thresh = 16'd1000; low = 0;
      do_reset();
      for (int c = 0; c < 50; c++) begin
        step();
        if (!cke) low++;
      end
      chk("R9 cke low cycles", low == 0, low, 0);
    end

    // R7 R8 R10: power-down entry, wake on request, grant pulse
    pd_en = 1'b1; ref_thresh = 16'd1000;
    do_reset();
    step();
    chk("R7 cke low when idle", cke == 1'b0, cke, 0);
    while (cyc < 5) step();
    acc_req = 1'b1;
    step(); // edge 6
    chk("R8 cke rises on request", cke == 1'b1, cke, 1);
    step();
    chk("R8 no early grant c7", acc_grant == 1'b0, acc_grant, 0);
    step();
    chk("R8 no early grant c8", acc_grant == 1'b0 && cke == 1'b1, acc_grant, 0);
    step();
    chk("R8 grant at wake+3", acc_grant == 1'b1, acc_grant, 1);
    acc_req = 1'b0;
    xact_active = 1'b1;
    step();
    chk("R10 grant single cycle", acc_grant == 1'b0, acc_grant, 0);
    step();
    step();
    chk("R7 cke held by transfer", cke == 1'b1, cke, 1);
    xact_active = 1'b0;
    step();
    chk("R7 cke drops after transfer", cke == 1'b0, cke, 0);

    // R5: due refresh beats access
    begin
      int strobes, gbad;
      pd_en = 1'b0; ref_thresh = 16'd20; gap_cyc = 4'd1; burst8 = 1'b0;
      strobes = 0; gbad = 0;
      do_reset();
      while (cyc < 20) step();
      acc_req = 1'b1;
      while (cyc < 31) begin
        step();
        if (ref_cmd) strobes++;
        if (acc_grant != (cyc == 30)) gbad++;
        if (acc_grant) acc_req = 1'b0;
      end
      chk("R5 grant held until after burst", gbad == 0, gbad, 0);
      chk("R5 burst not cut short", strobes == 4, strobes, 4);
    end

    // R6: refresh waits for transfer
    begin
      int first;
      pd_en = 1'b0; ref_thresh = 16'd20; xact_active = 1'b1;
      first = 0;
      do_reset();
      while (cyc < 30) begin
        step();
        if (ref_cmd && first == 0) first = cyc;
      end
      xact_active = 1'b0;
      while (cyc < 33) begin
        step();
        if (ref_cmd && first == 0) first = cyc;
      end
      chk("R6 first strobe after transfer", first == 32, first, 32);
    end

    // R11: refresh from power-down
    begin
      int kbad, sbad;
      pd_en = 1'b1; ref_thresh = 16'd40; gap_cyc = 4'd2; burst8 = 1'b0;
      kbad = 0; sbad = 0;
      do_reset();
      while (cyc < 57) begin
        logic ek, es;
        step();
        ek = (cyc >= 41 && cyc <= 55);
        es = (cyc == 45 || cyc == 48 || cyc == 51 || cyc == 54);
        if (cke != ek) begin
          kbad++;
          $display("FAIL R11 cke cyc=%0d actual=%0d expected=%0d", cyc, cke, ek);
        end
        if (ref_cmd != es) begin
          sbad++;
          $display("FAIL R11 strobe cyc=%0d actual=%0d expected=%0d", cyc, ref_cmd, es);
        end
      end
      chk("R11 cke profile", kbad == 0, kbad, 0);
      chk("R11 strobe profile", sbad == 0, sbad, 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule